// File: doc/BRIEF.md
# Descriptor-Driven Single-Channel DMA Engine

This block is one DMA channel for a 16-bit address space. When armed, it reads an eight-byte configuration record from memory at a given base address. The record supplies the source and destination addresses, a length limit, a length mode and the unit size. The channel then waits for pulses on one trigger line. A 5-bit select input picks that line from a 32-bit trigger vector, and each pulse moves exactly one unit from the source to the destination.

A unit is either a byte or a 16-bit word. A word is stored little-endian as two byte accesses. The number of units is either the programmed length or a value read from the first unit moved. In the second case a small offset is added to that value and the result is capped at the programmed length. The memory port is a single synchronous byte port: read data appears on the cycle after a read strobe. After the last unit is written, a one-cycle done pulse marks the end of the transfer and the channel goes idle until it is armed again.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset the channel is idle: busy, done, cfgErr, memRd and memWr are all low.
- R2: A pulse on armStart while idle reads the eight record bytes at descAddr, descAddr+1, …, descAddr+7 in that order. Bytes 0/1 are the source address (high byte, then low byte). Bytes 2/3 are the destination address (high, then low). Byte 4 bits 7:5 are the length mode. Byte 4 bits 4:0 followed by byte 5 form the 13-bit length LEN. Byte 6 bit 7 selects word units (1) or byte units (0). Byte 7 is unused.
- R3: While the channel waits, each pulse on trigVec[trigSel] moves one unit: a read of the source followed by a write of the same data to the destination. Pulses on the other trigger lines cause no memory write.
- R4: In byte mode both addresses advance by 1 per unit. In word mode the low byte is accessed at the address and the high byte at the address+1, and both addresses advance by 2.
- R5: Modes 000 and 111 move exactly LEN units.
- R6: In modes 001, 010, 011 and 100, the first unit gives a value v. In byte mode v is the byte. In word mode v is bits 12:0 of the little-endian word. The total number of units, counting the first unit, is v+1, v, v+2 and v+3 respectively.
- R7: In the variable modes the total is capped at LEN and is never less than 1.
- R8: Modes 101 and 110 move LEN units as in R5 and raise cfgErr. cfgErr stays high until the next arm, which clears it.
- R9: A LEN of zero finishes without any memory write and without needing a trigger.
- R10: done is high for exactly one cycle, no more than four cycles after the final write. Afterwards busy is low, and triggers cause no write until the channel is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armStart | input | 1 | Pulse: start fetching the record at descAddr |
| descAddr | input | 16 | Base address of the eight-byte record |
| trigSel | input | 5 | Selects the active trigger line |
| trigVec | input | 32 | Trigger pulse lines |
| memAddr | output | 16 | Memory byte address |
| memRd | output | 1 | Read strobe; data is returned on the next cycle |
| memWr | output | 1 | Write strobe |
| memWdata | output | 8 | Write data |
| memRdata | input | 8 | Read data |
| busy | output | 1 | High whenever the channel is not idle |
| done | output | 1 | One-cycle end-of-transfer pulse |
| cfgErr | output | 1 | A reserved length mode was used |

## Verification
The main function is driven with fixed-length transfers in byte and word units, which separate the address step and the byte order. Each variable mode is run with a first unit chosen so that the four offsets give different totals. A word whose upper three bits are set shows whether the 13-bit mask is applied. Further cases cover a first value above LEN (clamp), a first value of zero in the inclusive mode (floor of one), a reserved mode, and LEN of zero. Every run also pulses a non-selected line and then sends extra trigger pulses after completion, which exposes selection and stop faults.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  localparam int ADDR_W  = 16;
  localparam int LEN_W   = 13;
  localparam int DESC_N  = 8;
  localparam int IDX_W   = $clog2(DESC_N);
  localparam int BYTE_W  = 8;

  localparam logic [2:0] MODE_FIX    = 3'b000;
  localparam logic [2:0] MODE_PLUS1  = 3'b001;
  localparam logic [2:0] MODE_INCL   = 3'b010;
  localparam logic [2:0] MODE_PLUS2  = 3'b011;
  localparam logic [2:0] MODE_PLUS3  = 3'b100;
  localparam logic [2:0] MODE_RSV_A  = 3'b101;
  localparam logic [2:0] MODE_RSV_B  = 3'b110;
  localparam logic [2:0] MODE_FIXALT = 3'b111;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FCAP, ST_PARSE, ST_WAITT,
    ST_RD, ST_WR, ST_ADV, ST_CHK, ST_FIN
  } chState_t;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST, SEL_NONE} addrSel_t;

  typedef struct packed {
    logic             arm;
    logic             descCap;
    logic [IDX_W-1:0] descIdx;
    logic             parse;
    addrSel_t         addrSel;
    logic             hiByte;
    logic             capUnit;
    logic             advance;
  } pathCtl_t;

endpackage

// File: rtl/dma_eng_path.sv
module dma_eng_path
  import dma_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] descBase,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  output logic              isWord,
  output logic              lenZero,
  output logic              lastUnit,
  output logic              cfgErr
);

  localparam int CAND_W = LEN_W + 1;

  logic [ADDR_W-1:0] baseQ, srcQ, dstQ;
  logic [2:0]        modeQ;
  logic [LEN_W-1:0]  lenQ, movedQ, totalQ;
  logic              wordQ, errQ;
  logic [BYTE_W-1:0] firstLoQ, firstHiQ;

  logic              isVar;
  logic [LEN_W-1:0]  firstVal;
  logic [CAND_W-1:0] cand;
  logic [LEN_W-1:0]  capped, clampVal;
  logic [ADDR_W-1:0] step;

  assign isVar = (modeQ == MODE_PLUS1) || (modeQ == MODE_INCL) ||
                 (modeQ == MODE_PLUS2) || (modeQ == MODE_PLUS3);

  // first unit value: a byte, or 13 bits of a little-endian word
  assign firstVal = wordQ ? {firstHiQ[LEN_W-BYTE_W-1:0], firstLoQ}
                          : {{(LEN_W-BYTE_W){1'b0}}, firstLoQ};

  always_comb begin
    unique case (modeQ)
      MODE_PLUS1: cand = {1'b0, firstVal} + CAND_W'(1);
      MODE_PLUS2: cand = {1'b0, firstVal} + CAND_W'(2);
      MODE_PLUS3: cand = {1'b0, firstVal} + CAND_W'(3);
      default:    cand = {1'b0, firstVal};
    endcase
    capped   = (cand > {1'b0, lenQ}) ? lenQ : cand[LEN_W-1:0];
    clampVal = (capped == '0) ? LEN_W'(1) : capped;
  end

  assign step = wordQ ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      srcQ     <= '0;
      dstQ     <= '0;
      modeQ    <= MODE_FIX;
      lenQ     <= '0;
      movedQ   <= '0;
      totalQ   <= '0;
      wordQ    <= 1'b0;
      errQ     <= 1'b0;
      firstLoQ <= '0;
      firstHiQ <= '0;
    end else begin
      if (ctl.arm) begin
        baseQ    <= descBase;
        errQ     <= 1'b0;
        movedQ   <= '0;
        totalQ   <= '0;
        firstLoQ <= '0;
        firstHiQ <= '0;
      end
      if (ctl.descCap) begin
        unique case (ctl.descIdx)
          3'd0: srcQ[15:8] <= memRdata;
          3'd1: srcQ[7:0]  <= memRdata;
          3'd2: dstQ[15:8] <= memRdata;
          3'd3: dstQ[7:0]  <= memRdata;
          3'd4: begin
            modeQ       <= memRdata[7:5];
            lenQ[12:8]  <= memRdata[4:0];
          end
          3'd5: lenQ[7:0] <= memRdata;
          3'd6: wordQ     <= memRdata[7];
          default: ;
        endcase
      end
      if (ctl.parse) begin
        totalQ <= lenQ;
        errQ   <= (modeQ == MODE_RSV_A) || (modeQ == MODE_RSV_B);
      end
      if (ctl.capUnit && movedQ == '0) begin
        if (ctl.hiByte) firstHiQ <= memRdata;
        else            firstLoQ <= memRdata;
      end
      if (ctl.advance) begin
        srcQ   <= srcQ + step;
        dstQ   <= dstQ + step;
        movedQ <= movedQ + LEN_W'(1);
        if (isVar && movedQ == '0) totalQ <= clampVal;
      end
    end
  end

  always_comb begin
    unique case (ctl.addrSel)
      SEL_DESC: memAddr = baseQ + ADDR_W'(ctl.descIdx);
      SEL_SRC:  memAddr = srcQ + ADDR_W'(ctl.hiByte);
      SEL_DST:  memAddr = dstQ + ADDR_W'(ctl.hiByte);
      default:  memAddr = '0;
    endcase
  end

  assign memWdata = memRdata;
  assign isWord   = wordQ;
  assign lenZero  = (lenQ == '0);
  assign lastUnit = (movedQ >= totalQ);
  assign cfgErr   = errQ;

  // R7
  total_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && isVar && movedQ == '0) |=> (totalQ <= lenQ && totalQ != '0));

  // R10
  moved_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (movedQ <= totalQ));

endmodule

// File: rtl/dma_eng_ctrl.sv
module dma_eng_ctrl
  import dma_eng_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     armStart,
  input  logic     trigHit,
  input  logic     isWord,
  input  logic     lenZero,
  input  logic     lastUnit,
  output pathCtl_t ctl,
  output logic     memRd,
  output logic     memWr,
  output logic     busy,
  output logic     done
);

  chState_t         stateQ, stateD;
  logic [IDX_W-1:0] idxQ;
  logic             hiQ;

  always_comb begin
    stateD      = stateQ;
    ctl         = '0;
    ctl.addrSel = SEL_NONE;
    ctl.descIdx = idxQ;
    ctl.hiByte  = hiQ;
    memRd       = 1'b0;
    memWr       = 1'b0;
    done        = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (armStart) begin
        ctl.arm = 1'b1;
        stateD  = ST_FREQ;
      end
      ST_FREQ: begin
        ctl.addrSel = SEL_DESC;
        memRd       = 1'b1;
        stateD      = ST_FCAP;
      end
      ST_FCAP: begin
        ctl.descCap = 1'b1;
        stateD      = (idxQ == IDX_W'(DESC_N-1)) ? ST_PARSE : ST_FREQ;
      end
      ST_PARSE: begin
        ctl.parse = 1'b1;
        stateD    = lenZero ? ST_FIN : ST_WAITT;
      end
      ST_WAITT: if (trigHit) stateD = ST_RD;
      ST_RD: begin
        ctl.addrSel = SEL_SRC;
        memRd       = 1'b1;
        stateD      = ST_WR;
      end
      ST_WR: begin
        ctl.addrSel = SEL_DST;
        ctl.capUnit = 1'b1;
        memWr       = 1'b1;
        stateD      = (isWord && !hiQ) ? ST_RD : ST_ADV;
      end
      ST_ADV: begin
        ctl.advance = 1'b1;
        stateD      = ST_CHK;
      end
      ST_CHK: stateD = lastUnit ? ST_FIN : ST_WAITT;
      ST_FIN: begin
        done   = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      hiQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_IDLE)      idxQ <= '0;
      else if (stateQ == ST_FCAP) idxQ <= idxQ + IDX_W'(1);
      if (stateQ == ST_WAITT)                 hiQ <= 1'b0;
      else if (stateQ == ST_WR && isWord)     hiQ <= ~hiQ;
    end
  end

  assign busy = (stateQ != ST_IDLE);

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> $past(memRd));

  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memWr && !memRd && !done));

endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_eng_pkg::*;
#(
  parameter int TRIG_SEL_W = 5,
  localparam int TRIG_N    = 1 << TRIG_SEL_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  armStart,
  input  logic [ADDR_W-1:0]     descAddr,
  input  logic [TRIG_SEL_W-1:0] trigSel,
  input  logic [TRIG_N-1:0]     trigVec,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memRd,
  output logic                  memWr,
  output logic [BYTE_W-1:0]     memWdata,
  input  logic [BYTE_W-1:0]     memRdata,
  output logic                  busy,
  output logic                  done,
  output logic                  cfgErr
);

  pathCtl_t ctl;
  logic     trigHit, isWord, lenZero, lastUnit;

  assign trigHit = trigVec[trigSel];

  dma_eng_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .armStart (armStart),
    .trigHit  (trigHit),
    .isWord   (isWord),
    .lenZero  (lenZero),
    .lastUnit (lastUnit),
    .ctl      (ctl),
    .memRd    (memRd),
    .memWr    (memWr),
    .busy     (busy),
    .done     (done)
  );

  dma_eng_path u_path (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .descBase (descAddr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .isWord   (isWord),
    .lenZero  (lenZero),
    .lastUnit (lastUnit),
    .cfgErr   (cfgErr)
  );

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !armStart) |=> cfgErr);

endmodule

// File: tb/sim_dma_desc_engine.sv
module sim_dma_desc_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        armStart;
  logic [15:0] descAddr;
  logic [4:0]  trigSel;
  logic [31:0] trigVec;
  logic [15:0] memAddr;
  logic        memRd, memWr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;
  logic        busy, done, cfgErr;

  always #10 clk = ~clk;

  dma_desc_engine u0 (
    .clk(clk), .rstN(rstN), .armStart(armStart), .descAddr(descAddr),
    .trigSel(trigSel), .trigVec(trigVec), .memAddr(memAddr), .memRd(memRd),
    .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .cfgErr(cfgErr)
  );

  // memory model with a bench load path
  logic [7:0] mem [0:1023];
  logic [7:0] img [0:1023];
  logic       tbWe;
  logic [9:0] tbA;
  logic [7:0] tbD;

  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr[9:0]];
    if (memWr) mem[memAddr[9:0]] <= memWdata;
    else if (tbWe) mem[tbA] <= tbD;
  end

  int checkCnt = 0;
  int failCnt  = 0;
  int wrCnt    = 0;
  int doneCnt  = 0;
  bit started  = 1'b0;
  bit prevDone = 1'b0;
  logic [23:0] expQ[$];
  string       tagQ[$];

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  // monitor: pop expected writes and compare
  always @(negedge clk) begin
    if (started) begin
      if (memWr) begin
        wrCnt++;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "unexpected write addr", int'(memAddr), 0);
        end else begin
          logic [23:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk({memAddr, memWdata} == e, t, "write addr/data",
              int'({memAddr, memWdata}), int'(e));
        end
      end
      if (done) begin
        doneCnt++;
        if (prevDone) chk(1'b0, "R10", "done wider than one cycle", 2, 1);
      end
      prevDone = done;
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic poke(int a, int d);
    @(negedge clk);
    tbWe = 1'b1;
    tbA  = a[9:0];
    tbD  = d[7:0];
    img[a[9:0]] = d[7:0];
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic pulse(int line);
    @(negedge clk);
    trigVec = 32'd1 << line;
    @(negedge clk);
    trigVec = '0;
    repeat (10) @(negedge clk);
  endtask

  localparam int DESC = 'h040;
  localparam int SRC  = 'h100;
  localparam int DST  = 'h200;
  localparam int SEL  = 14;

  // mode: 3-bit length mode, w: word units, len: 13-bit limit, first: first unit value
  task automatic runXfer(string tag, int mode, bit w, int len, int first, bit expErr);
    int ub, n, v, cand, nb, w0;
    ub = w ? 2 : 1;
    poke(DESC + 0, SRC >> 8);
    poke(DESC + 1, SRC & 'hFF);
    poke(DESC + 2, DST >> 8);
    poke(DESC + 3, DST & 'hFF);
    poke(DESC + 4, ((mode & 7) << 5) | ((len >> 8) & 'h1F));
    poke(DESC + 5, len & 'hFF);
    poke(DESC + 6, w ? 'h80 : 'h00);
    poke(DESC + 7, 'h5A);
    poke(SRC, first & 'hFF);
    poke(SRC + 1, w ? ((first >> 8) & 'hFF) : 'hA1);
    for (int i = 2; i < 24; i++) poke(SRC + i, 'hA0 + i * 3);
    // expected unit count from the requirements
    if (mode >= 1 && mode <= 4) begin
      v = w ? (first & 'h1FFF) : (first & 'hFF);
      case (mode)
        1: cand = v + 1;
        2: cand = v;
        3: cand = v + 2;
        default: cand = v + 3;
      endcase
      n = (cand > len) ? len : cand;
      if (n == 0) n = 1;
      if (len == 0) n = 0;
    end else begin
      n = len;
    end
    nb = n * ub;
    for (int i = 0; i < nb; i++) begin
      expQ.push_back({16'(DST + i), img[SRC + i]});
      tagQ.push_back(tag);
    end
    doneCnt = 0;
    @(negedge clk);
    descAddr = 16'(DESC);
    armStart = 1'b1;
    @(negedge clk);
    armStart = 1'b0;
    repeat (25) @(negedge clk);
    // R3: a pulse on a different line moves nothing
    w0 = wrCnt;
    pulse((SEL + 1) % 32);
    chk(wrCnt == w0, "R3", "write after non-selected trigger", wrCnt - w0, 0);
    for (int k = 0; k < n + 2; k++) pulse(SEL);
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0, tag, "writes missing", expQ.size(), 0);
    chk(doneCnt == 1, "R10", "done pulses", doneCnt, 1);
    chk(cfgErr == expErr, "R8", "cfgErr", int'(cfgErr), int'(expErr));
    chk(busy == 1'b0, "R10", "busy after done", int'(busy), 0);
    expQ.delete();
    tagQ.delete();
  endtask

  initial begin
    rstN     = 1'b0;
    armStart = 1'b0;
    descAddr = '0;
    trigSel  = 5'(SEL);
    trigVec  = '0;
    tbWe     = 1'b0;
    tbA      = '0;
    tbD      = '0;
    for (int i = 0; i < 1024; i++) img[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0,   "R1", "busy",   int'(busy), 0);
    chk(done == 1'b0,   "R1", "done",   int'(done), 0);
    chk(cfgErr == 1'b0, "R1", "cfgErr", int'(cfgErr), 0);
    chk(memRd == 1'b0 && memWr == 1'b0, "R1", "mem strobes", int'({memRd, memWr}), 0);
    started = 1'b1;
    // R10: trigger while idle moves nothing
    pulse(SEL);
    chk(wrCnt == 0, "R10", "write while idle", wrCnt, 0);

    runXfer("R5", 0, 1'b0, 4, 'h33, 1'b0);      // R2 R4 byte fixed
    runXfer("R4", 7, 1'b1, 3, 'h1234, 1'b0);    // word fixed, alt mode
    runXfer("R6", 1, 1'b0, 10, 2, 1'b0);        // v+1 -> 3
    runXfer("R6", 2, 1'b0, 10, 4, 1'b0);        // v -> 4
    runXfer("R6", 3, 1'b0, 10, 1, 1'b0);        // v+2 -> 3
    runXfer("R6", 4, 1'b1, 8, 'hE002, 1'b0);    // word, 13-bit mask, v+3 -> 5
    runXfer("R7", 3, 1'b0, 4, 20, 1'b0);        // clamp to LEN
    runXfer("R7", 2, 1'b0, 6, 0, 1'b0);         // floor of one
    runXfer("R8", 5, 1'b0, 2, 'h77, 1'b1);      // reserved mode
    runXfer("R9", 0, 1'b0, 0, 'h11, 1'b0);      // LEN zero, clears cfgErr
    finishRun();
  end

endmodule